// File: doc/BRIEF.md
# Immediate-Operand Register Execute Unit

This unit executes the five instruction groups of a 16-bit-instruction microcontroller that carry an 8-bit immediate operand. An instruction word holds a 4-bit opcode in bits 15:12, a register number in bits 11:8 and an immediate in bits 7:0. When the valid strobe is high, the unit reads the named register through a read port of an external sixteen-entry register file of 16-bit registers. It applies the operation and presents the result on a write port one cycle later. The register file is expected to commit a write at the clock edge that ends the cycle in which the write strobe is high.

There are five operations. One loads the immediate into the low byte. One clears low-byte bits that the immediate selects as a mask. One sets low-byte bits that the mask selects. The last two add or subtract the immediate plus one across the full register width. Register 0 holds the program counter, so any result written to it also raises a one-cycle redirect carrying the new fetch address. Adding or subtracting on register 0 therefore gives a relative jump of 1 to 256. A result still waiting in the unit's output stage is forwarded to a following instruction that names the same register, so instructions may be issued on every cycle.

Top module: `imm_exec_unit`

## Requirements
- R1: While reset is held and in the first cycle after its release, `rf_we` and `redir_valid` are 0.
- R2: Opcode 0x8 writes `{old[15:8], imm}`: the low byte becomes the immediate and the high byte is unchanged.
- R3: Opcode 0x9 writes `old & ~{8'h00, imm}`: mask bits clear the low byte and the high byte is unchanged.
- R4: Opcode 0xB writes `old | {8'h00, imm}`: mask bits set the low byte and the high byte is unchanged.
- R5: Opcode 0xA writes `(old + imm + 1) mod 2^16`, so imm 0x00 adds 1 and imm 0xFF adds 256.
- R6: Opcode 0xF writes `(old - imm - 1) mod 2^16`, so imm 0x00 subtracts 1.
- R7: A valid instruction with one of the five opcodes produces `rf_we` = 1 for exactly the next cycle, with `rf_waddr` equal to its bits 11:8.
- R8: When `in_valid` is 0, or the opcode is any other value, there is no write and no redirect in the next cycle.
- R9: A write to register 0 raises `redir_valid` in the same cycle, with `redir_addr` equal to the written value. A write to any other register leaves `redir_valid` at 0.
- R10: `rf_raddr` equals bits 11:8 of `in_instr` in the same cycle, with no register in the path.
- R11: An instruction that names the register written by the instruction just before it uses that instruction's result as its old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Instruction word is valid this cycle |
| in_instr | input | 16 | Instruction: opcode 15:12, register 11:8, immediate 7:0 |
| rf_raddr | output | 4 | Register file read address |
| rf_rdata | input | 16 | Register file read data, same cycle |
| rf_we | output | 1 | Register file write strobe |
| rf_waddr | output | 4 | Register file write address |
| rf_wdata | output | 16 | Register file write data |
| redir_valid | output | 1 | Program counter redirect, one cycle |
| redir_addr | output | 16 | New fetch address |

## Verification
The bench checks the add immediates at their edges. An immediate of 0xFF on 0xFFFF must wrap to 0x00FF, and a subtract of 0x00 from 0 must give 0xFFFF. A design that drops the implied one, or keeps only eight bits of the sum, gives a result off by one or a lost carry into the high byte. The bench also applies the load, clear and set operations to registers whose high bytes are not zero, which catches a mask that reaches above the low byte. Instructions naming the same register are issued back to back, so a design without forwarding reads the stale value and is caught. Redirects are checked on register 0 and checked absent on other registers, and instructions with other opcodes or with the strobe low are checked to cause no write.

// File: rtl/imm_exec_pkg.sv
package imm_exec_pkg;

   localparam int unsigned OPC_W = 4;

   localparam logic [OPC_W-1:0] OPC_LOAD = 4'h8;
   localparam logic [OPC_W-1:0] OPC_CLR  = 4'h9;
   localparam logic [OPC_W-1:0] OPC_ADD  = 4'hA;
   localparam logic [OPC_W-1:0] OPC_SET  = 4'hB;
   localparam logic [OPC_W-1:0] OPC_SUB  = 4'hF;

   typedef enum logic [2:0] {
      OP_NONE,
      OP_LOAD,
      OP_CLR,
      OP_SET,
      OP_ADD,
      OP_SUB
   } imm_op_e;

endpackage

// File: rtl/imm_decode.sv
module imm_decode
   import imm_exec_pkg::*;
#(
   parameter int unsigned ADDR_W = 4,
   parameter int unsigned IMM_W  = 8,
   localparam int unsigned INSTR_W = OPC_W + ADDR_W + IMM_W
) (
   input  logic [INSTR_W-1:0] instr,
   input  logic               valid,
   output imm_op_e            op,
   output logic               hit,
   output logic [ADDR_W-1:0]  reg_idx,
   output logic [IMM_W-1:0]   imm
);

   logic [OPC_W-1:0] opc;

   assign opc     = instr[INSTR_W-1 -: OPC_W];
   assign reg_idx = instr[IMM_W +: ADDR_W];
   assign imm     = instr[IMM_W-1:0];

   always_comb begin
      unique case (opc)
         OPC_LOAD: op = OP_LOAD;
         OPC_CLR:  op = OP_CLR;
         OPC_SET:  op = OP_SET;
         OPC_ADD:  op = OP_ADD;
         OPC_SUB:  op = OP_SUB;
         default:  op = OP_NONE;
      endcase
   end

   assign hit = valid && (op != OP_NONE);

endmodule

// File: rtl/imm_alu.sv
module imm_alu
   import imm_exec_pkg::*;
#(
   parameter int unsigned DATA_W       = 16,
   parameter int unsigned IMM_W        = 8,
   parameter bit          SHARED_ADDER = 1'b1
) (
   input  imm_op_e            op,
   input  logic [DATA_W-1:0]  opnd,
   input  logic [IMM_W-1:0]   imm,
   output logic [DATA_W-1:0]  result
);

   localparam int unsigned HI_W = DATA_W - IMM_W;

   logic [DATA_W-1:0] imm_ext;
   logic [DATA_W-1:0] arith;

   assign imm_ext = {{HI_W{1'b0}}, imm};

   generate
      if (SHARED_ADDER) begin : g_shared
         // -(k+1) equals ~k, so one adder covers both directions.
         logic              is_sub;
         logic [DATA_W-1:0] addend;
         logic [DATA_W-1:0] carry_in;
         assign is_sub   = (op == OP_SUB);
         assign addend   = is_sub ? ~imm_ext : imm_ext;
         assign carry_in = {{(DATA_W-1){1'b0}}, ~is_sub};
         assign arith    = opnd + addend + carry_in;
      end else begin : g_split
         logic [DATA_W-1:0] up;
         logic [DATA_W-1:0] down;
         assign up    = opnd + imm_ext + {{(DATA_W-1){1'b0}}, 1'b1};
         assign down  = opnd - imm_ext - {{(DATA_W-1){1'b0}}, 1'b1};
         assign arith = (op == OP_SUB) ? down : up;
      end
   endgenerate

   always_comb begin
      unique case (op)
         OP_LOAD: result = {opnd[DATA_W-1:IMM_W], imm};
         OP_CLR:  result = opnd & ~imm_ext;
         OP_SET:  result = opnd | imm_ext;
         OP_ADD,
         OP_SUB:  result = arith;
         default: result = opnd;
      endcase
   end

endmodule

// File: rtl/imm_wb.sv
module imm_wb #(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_req,
   input  logic [ADDR_W-1:0] wr_idx,
   input  logic [DATA_W-1:0] wr_val,
   output logic              we_q,
   output logic [ADDR_W-1:0] waddr_q,
   output logic [DATA_W-1:0] wdata_q,
   output logic              redir_q
);

   logic to_pc;

   assign to_pc = wr_req && (wr_idx == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         we_q    <= 1'b0;
         waddr_q <= '0;
         wdata_q <= '0;
         redir_q <= 1'b0;
      end else begin
         we_q    <= wr_req;
         redir_q <= to_pc;
         if (wr_req) begin
            waddr_q <= wr_idx;
            wdata_q <= wr_val;
         end
      end
   end

   p_redir_pc_r9: assert property (@(posedge clk) disable iff (!rst_n)
      redir_q |-> (we_q && (waddr_q == '0)));

   p_one_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_req |=> !we_q);

endmodule

// File: rtl/imm_exec_unit.sv
module imm_exec_unit
   import imm_exec_pkg::*;
#(
   parameter int unsigned DATA_W       = 16,
   parameter int unsigned NREG         = 16,
   parameter int unsigned IMM_W        = 8,
   parameter bit          SHARED_ADDER = 1'b1,
   localparam int unsigned ADDR_W  = $clog2(NREG),
   localparam int unsigned INSTR_W = OPC_W + ADDR_W + IMM_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   input  logic [INSTR_W-1:0] in_instr,
   output logic [ADDR_W-1:0]  rf_raddr,
   input  logic [DATA_W-1:0]  rf_rdata,
   output logic               rf_we,
   output logic [ADDR_W-1:0]  rf_waddr,
   output logic [DATA_W-1:0]  rf_wdata,
   output logic               redir_valid,
   output logic [DATA_W-1:0]  redir_addr
);

   localparam int unsigned HI_W = DATA_W - IMM_W;

   generate
      if (IMM_W >= DATA_W) begin : g_bad_imm
         $error("imm_exec_unit: IMM_W must be narrower than DATA_W");
      end
      if (NREG < 2 || NREG != (1 << ADDR_W)) begin : g_bad_nreg
         $error("imm_exec_unit: NREG must be a power of two of at least 2");
      end
   endgenerate

   imm_op_e           op;
   logic              hit;
   logic [ADDR_W-1:0] reg_idx;
   logic [IMM_W-1:0]  imm;
   logic              fwd;
   logic [DATA_W-1:0] opnd;
   logic [DATA_W-1:0] result;

   imm_decode #(
      .ADDR_W (ADDR_W),
      .IMM_W  (IMM_W)
   ) u_dec (
      .instr   (in_instr),
      .valid   (in_valid),
      .op      (op),
      .hit     (hit),
      .reg_idx (reg_idx),
      .imm     (imm)
   );

   assign rf_raddr = reg_idx;

   // The file commits rf_wdata only at the end of this cycle: bypass it.
   assign fwd  = rf_we && (rf_waddr == reg_idx);
   assign opnd = fwd ? rf_wdata : rf_rdata;

   imm_alu #(
      .DATA_W       (DATA_W),
      .IMM_W        (IMM_W),
      .SHARED_ADDER (SHARED_ADDER)
   ) u_alu (
      .op     (op),
      .opnd   (opnd),
      .imm    (imm),
      .result (result)
   );

   imm_wb #(
      .DATA_W (DATA_W),
      .ADDR_W (ADDR_W)
   ) u_wb (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_req  (hit),
      .wr_idx  (reg_idx),
      .wr_val  (result),
      .we_q    (rf_we),
      .waddr_q (rf_waddr),
      .wdata_q (rf_wdata),
      .redir_q (redir_valid)
   );

   assign redir_addr = rf_wdata;

   logic [OPC_W-1:0]  opc_in;
   logic [DATA_W-1:0] imm_wide;
   assign opc_in   = in_instr[INSTR_W-1 -: OPC_W];
   assign imm_wide = {{HI_W{1'b0}}, in_instr[IMM_W-1:0]};

   p_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(in_valid && (opc_in == OPC_LOAD || opc_in == OPC_CLR || opc_in == OPC_SET
                     || opc_in == OPC_ADD || opc_in == OPC_SUB))
      |=> (!rf_we && !redir_valid));

   p_waddr_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && opc_in == OPC_ADD) |=> (rf_we && rf_waddr == $past(rf_raddr)));

   p_add_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && opc_in == OPC_ADD)
      |=> (rf_wdata == $past(opnd) + $past(imm_wide) + {{(DATA_W-1){1'b0}}, 1'b1}));

   p_sub_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && opc_in == OPC_SUB)
      |=> (rf_wdata == $past(opnd) - $past(imm_wide) - {{(DATA_W-1){1'b0}}, 1'b1}));

   p_high_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && (opc_in == OPC_LOAD || opc_in == OPC_CLR || opc_in == OPC_SET))
      |=> (rf_wdata[DATA_W-1:IMM_W] == $past(opnd[DATA_W-1:IMM_W])));

   p_redir_val_r9: assert property (@(posedge clk) disable iff (!rst_n)
      redir_valid |-> (redir_addr == rf_wdata && rf_we));

endmodule

// File: tb/sim_imm_exec_unit.sv
module sim_imm_exec_unit;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [15:0] in_instr = '0;
   logic [3:0]  rf_raddr;
   logic [15:0] rf_rdata;
   logic        rf_we;
   logic [3:0]  rf_waddr;
   logic [15:0] rf_wdata;
   logic        redir_valid;
   logic [15:0] redir_addr;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [15:0] rf [16];
   logic [15:0] mregs [16];

   always #(CLK_PERIOD/2) clk = ~clk;

   imm_exec_unit u0 (
      .clk         (clk),
      .rst_n       (rst_n),
      .in_valid    (in_valid),
      .in_instr    (in_instr),
      .rf_raddr    (rf_raddr),
      .rf_rdata    (rf_rdata),
      .rf_we       (rf_we),
      .rf_waddr    (rf_waddr),
      .rf_wdata    (rf_wdata),
      .redir_valid (redir_valid),
      .redir_addr  (redir_addr)
   );

   assign rf_rdata = rf[rf_raddr];

   always @(posedge clk) begin
      if (rf_we) rf[rf_waddr] <= rf_wdata;
   end

   function automatic bit is_imm(input logic [3:0] opc);
      return opc == 4'h8 || opc == 4'h9 || opc == 4'hA || opc == 4'hB || opc == 4'hF;
   endfunction

   function automatic logic [15:0] model(input logic [3:0] opc, input logic [15:0] a,
                                         input logic [7:0] k);
      case (opc)
         4'h8:    return {a[15:8], k};
         4'h9:    return a & {8'hFF, ~k};
         4'hB:    return a | {8'h00, k};
         4'hA:    return a + {8'h00, k} + 16'd1;
         4'hF:    return a - {8'h00, k} - 16'd1;
         default: return a;
      endcase
   endfunction

   function automatic string tag_of(input logic [3:0] opc);
      case (opc)
         4'h8:    return "R2";
         4'h9:    return "R3";
         4'hB:    return "R4";
         4'hA:    return "R5";
         4'hF:    return "R6";
         default: return "R8";
      endcase
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [15:0] act,
                      input logic [15:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   // Called at a falling edge; returns at the next falling edge after checking.
   task automatic step(input logic v, input logic [15:0] ins);
      logic [3:0]  opc;
      logic [3:0]  r;
      logic        exp_we;
      logic [15:0] exp_val;
      opc = ins[15:12];
      r   = ins[11:8];
      in_valid = v;
      in_instr = ins;
      #1;
      chk(rf_raddr == r, "R10", {12'h0, rf_raddr}, {12'h0, r});
      exp_we  = v && is_imm(opc);
      exp_val = model(opc, mregs[r], ins[7:0]);
      if (exp_we) mregs[r] = exp_val;
      @(negedge clk);
      chk(rf_we == exp_we, exp_we ? "R7" : "R8", {15'h0, rf_we}, {15'h0, exp_we});
      chk(redir_valid == (exp_we && r == 4'd0), "R9", {15'h0, redir_valid},
          {15'h0, exp_we && r == 4'd0});
      if (exp_we) begin
         chk(rf_waddr == r, "R7", {12'h0, rf_waddr}, {12'h0, r});
         chk(rf_wdata == exp_val, tag_of(opc), rf_wdata, exp_val);
         if (r == 4'd0) chk(redir_addr == exp_val, "R9", redir_addr, exp_val);
      end
   endtask

   function automatic logic [15:0] mk(input logic [3:0] opc, input logic [3:0] r,
                                      input logic [7:0] k);
      return {opc, r, k};
   endfunction

   initial begin
      for (int i = 0; i < 16; i++) begin
         rf[i] = '0;
         mregs[i] = '0;
      end
      void'($urandom(32'h1D5E_ED01));
      repeat (3) @(negedge clk);
      chk(!rf_we && !redir_valid, "R1", {14'h0, rf_we, redir_valid}, 16'h0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!rf_we && !redir_valid, "R1", {14'h0, rf_we, redir_valid}, 16'h0);

      // Directed corner cases (R5, R6 wrap; R11 back-to-back on one register)
      step(1'b1, mk(4'hF, 4'd3, 8'h00));   // 0 - 1 = FFFF
      step(1'b1, mk(4'hA, 4'd3, 8'hFF));   // FFFF + 256 = 00FF
      step(1'b1, mk(4'hA, 4'd3, 8'h00));   // + 1
      step(1'b1, mk(4'hA, 4'd3, 8'hFF));   // carry into high byte
      step(1'b1, mk(4'h8, 4'd3, 8'h5A));   // R2: high byte kept
      step(1'b1, mk(4'h9, 4'd3, 8'h0F));   // R3
      step(1'b1, mk(4'hB, 4'd3, 8'hC3));   // R4
      step(1'b0, mk(4'hA, 4'd3, 8'h10));   // R8: strobe low
      step(1'b1, mk(4'h3, 4'd3, 8'h10));   // R8: other opcode
      step(1'b1, mk(4'hC, 4'd0, 8'h10));   // R8: no redirect either
      step(1'b1, mk(4'hA, 4'd0, 8'hFF));   // R9: jump forward 256
      step(1'b1, mk(4'hF, 4'd0, 8'h01));   // R9: jump back 2, forwarded
      step(1'b1, mk(4'h8, 4'd7, 8'h77));   // R9: no redirect for R7 target
      step(1'b0, 16'h0000);

      // Constrained random, biased toward the five opcodes and register 0
      for (int n = 0; n < 3000; n++) begin
         logic [3:0] opc;
         logic [3:0] r;
         logic [2:0] sel;
         sel = 3'($urandom_range(0, 7));
         case (sel)
            3'd0: opc = 4'h8;
            3'd1: opc = 4'h9;
            3'd2: opc = 4'hA;
            3'd3: opc = 4'hB;
            3'd4: opc = 4'hF;
            3'd5: opc = 4'hA;
            default: opc = 4'($urandom_range(0, 15));
         endcase
         r = ($urandom_range(0, 3) == 0) ? 4'd0 : 4'($urandom_range(0, 15));
         step($urandom_range(0, 7) != 0, mk(opc, r, 8'($urandom_range(0, 255))));
      end
      step(1'b0, 16'h0000);
      step(1'b0, 16'h0000);

      // Committed file must match the architectural model (R7, R11)
      for (int i = 0; i < 16; i++) begin
         chk(rf[i] == mregs[i], "R11", rf[i], mregs[i]);
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule